// File: doc/BRIEF.md
# Thermal Alarm Event Output Logic

This block watches a stream of signed temperature samples and compares each valid sample with three programmable limits: the low and high edges of an allowed window and a separate critical limit. From these comparisons it drives an active-low event pin and three status flags that tell which limit tripped. The limits, the mode select, the event enable and a one-cycle software clear pulse arrive as plain parallel inputs. Bus access, register decoding and the temperature conversion itself are handled elsewhere.

Three behaviours can be selected. In the latching (interrupt) mode, a window excursion holds the pin low until software clears it, and the pin re-arms only after the temperature has come back inside the window. In comparator mode, the pin follows the present out-of-range condition, and the clear pulse has no effect. In critical-only mode, window excursions are ignored. In every mode, a critical excursion holds the pin low for as long as the latest sample stays above the critical limit, and software cannot release it.

Top module: `thermal_event_ctrl`

## Requirements
- R1: A synchronous active-high reset drives `event_n` high, clears all status flags and any latched window event, arms the window detector and loads the latching mode (code 0) into the internal mode register. Outside reset, that register loads `mode_sel` on every clock.
- R2: Samples and limits are 13-bit two's-complement values (0.0625 °C per LSB), compared as signed numbers. The status flags are `stat_above_high` = sample > high, `stat_below_low` = sample < low and `stat_above_crit` = sample > critical. A sample equal to a limit does not trip it. The flags load only when `samp_valid` is high, in every mode, and hold their value otherwise.
- R3: `event_n` and the status flags are registered. A sample presented with `samp_valid` on a clock edge is reflected at that edge and not before it.
- R4: With mode code 0 (latching), an out-of-window sample taken while the detector is armed latches a window event and drives `event_n` low.
- R5: With mode code 0, `sw_clear` releases a latched window event even while the temperature is still out of range. A new window event needs an in-window sample followed by an out-of-window sample. If a clear and an arming excursion arrive in the same cycle, the new event wins.
- R6: With mode code 1 (comparator), `event_n` is low exactly while the latest status shows any tripped flag. `sw_clear` has no effect.
- R7: With mode code 2 or 3 (critical-only), `event_n` is low exactly while `stat_above_crit` is set. Window excursions are ignored.
- R8: In every mode, a sample above the critical limit drives `event_n` low. `sw_clear` cannot release it, and it clears only on a sample at or below the critical limit.
- R9: While `evt_en` is low, `event_n` is held high and the status flags keep tracking. Raising `evt_en` while a condition is present drives `event_n` low at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| samp_valid | input | 1 | Sample strobe |
| samp_temp | input | 13 | Signed temperature sample |
| lim_low | input | 13 | Signed low window limit |
| lim_high | input | 13 | Signed high window limit |
| lim_crit | input | 13 | Signed critical limit |
| mode_sel | input | 2 | 0 latching, 1 comparator, 2/3 critical-only |
| evt_en | input | 1 | Event pin enable |
| sw_clear | input | 1 | One-cycle software clear |
| event_n | output | 1 | Active-low event pin |
| stat_above_high | output | 1 | Last valid sample above high limit |
| stat_below_low | output | 1 | Last valid sample below low limit |
| stat_above_crit | output | 1 | Last valid sample above critical limit |

## Verification
Each mode is run with a slow rising ramp and a slow falling ramp through all three limits. These ramps show whether each limit is crossed at exactly the right sample, including the sample that equals the limit. Clear pulses, gaps in the strobe and a disabled stretch are spread over the ramps. They show whether the latched window event, the re-arm rule and the non-clearable critical event behave differently by mode, as they must. A scrambled-order sweep makes large jumps straight across the window, so an event raised with no re-entry in between is told apart from a true re-arm. Directed cases cover the equal-to-limit samples, negative temperatures, the same-cycle clear-and-set priority and the pin level just before the sampling edge.

// File: rtl/thermal_pkg.sv
package thermal_pkg;

  typedef enum logic [1:0] {
    MODE_INTR     = 2'd0,
    MODE_CMP      = 2'd1,
    MODE_CRIT     = 2'd2,
    MODE_CRIT_ALT = 2'd3
  } evt_mode_e;

  typedef struct packed {
    logic above_high;
    logic below_low;
    logic above_crit;
  } lim_flags_t;

endpackage

// File: rtl/limit_cmp.sv
module limit_cmp
  import thermal_pkg::*;
#(
  parameter int TEMP_W = 13
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     samp_valid,
  input  logic signed [TEMP_W-1:0] samp_temp,
  input  logic signed [TEMP_W-1:0] lim_low,
  input  logic signed [TEMP_W-1:0] lim_high,
  input  logic signed [TEMP_W-1:0] lim_crit,
  output lim_flags_t               flags_now,
  output lim_flags_t               flags_d,
  output lim_flags_t               flags_q
);

  always_comb begin
    flags_now.above_high = (samp_temp > lim_high);
    flags_now.below_low  = (samp_temp < lim_low);
    flags_now.above_crit = (samp_temp > lim_crit);
    flags_d = samp_valid ? flags_now : flags_q;
  end

  always_ff @(posedge clk) begin
    if (rst) flags_q <= '0;
    else     flags_q <= flags_d;
  end

endmodule

// File: rtl/window_latch.sv
module window_latch (
  input  logic clk,
  input  logic rst,
  input  logic samp_valid,
  input  logic out_now,
  input  logic intr_mode,
  input  logic sw_clear,
  output logic latch_d
);

  logic latch_q, armed_q, armed_d;

  always_comb begin
    latch_d = latch_q;
    armed_d = armed_q;
    if (!intr_mode) begin
      latch_d = 1'b0;
      if (samp_valid) armed_d = !out_now;
    end else begin
      if (sw_clear) latch_d = 1'b0;
      if (samp_valid) begin
        if (!out_now) begin
          armed_d = 1'b1;
        end else if (armed_q) begin
          latch_d = 1'b1;
          armed_d = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q <= 1'b0;
      armed_q <= 1'b1;
    end else begin
      latch_q <= latch_d;
      armed_q <= armed_d;
    end
  end

endmodule

// File: rtl/event_drive.sv
module event_drive
  import thermal_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  evt_mode_e  mode,
  input  logic       evt_en,
  input  logic       latch_d,
  input  lim_flags_t flags_d,
  output logic       event_n
);

  logic alarm;

  always_comb begin
    unique case (mode)
      MODE_INTR: alarm = latch_d | flags_d.above_crit;
      MODE_CMP:  alarm = flags_d.above_high | flags_d.below_low | flags_d.above_crit;
      default:   alarm = flags_d.above_crit;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) event_n <= 1'b1;
    else     event_n <= ~(evt_en & alarm);
  end

endmodule

// File: rtl/thermal_event_ctrl.sv
module thermal_event_ctrl
  import thermal_pkg::*;
#(
  parameter int TEMP_W = 13
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     samp_valid,
  input  logic signed [TEMP_W-1:0] samp_temp,
  input  logic signed [TEMP_W-1:0] lim_low,
  input  logic signed [TEMP_W-1:0] lim_high,
  input  logic signed [TEMP_W-1:0] lim_crit,
  input  logic [1:0]               mode_sel,
  input  logic                     evt_en,
  input  logic                     sw_clear,
  output logic                     event_n,
  output logic                     stat_above_high,
  output logic                     stat_below_low,
  output logic                     stat_above_crit
);

  evt_mode_e  mode_q;
  lim_flags_t flags_now, flags_d, flags_q;
  logic       latch_d;

  // Mode register: reset selects latching mode
  always_ff @(posedge clk) begin
    if (rst) mode_q <= MODE_INTR;
    else     mode_q <= evt_mode_e'(mode_sel);
  end

  limit_cmp #(.TEMP_W(TEMP_W)) u_cmp (
    .clk        (clk),
    .rst        (rst),
    .samp_valid (samp_valid),
    .samp_temp  (samp_temp),
    .lim_low    (lim_low),
    .lim_high   (lim_high),
    .lim_crit   (lim_crit),
    .flags_now  (flags_now),
    .flags_d    (flags_d),
    .flags_q    (flags_q)
  );

  window_latch u_win (
    .clk        (clk),
    .rst        (rst),
    .samp_valid (samp_valid),
    .out_now    (flags_now.above_high | flags_now.below_low),
    .intr_mode  (mode_q == MODE_INTR),
    .sw_clear   (sw_clear),
    .latch_d    (latch_d)
  );

  event_drive u_drv (
    .clk     (clk),
    .rst     (rst),
    .mode    (mode_q),
    .evt_en  (evt_en),
    .latch_d (latch_d),
    .flags_d (flags_d),
    .event_n (event_n)
  );

  assign stat_above_high = flags_q.above_high;
  assign stat_below_low  = flags_q.below_low;
  assign stat_above_crit = flags_q.above_crit;

endmodule

// File: rtl/thermal_event_chk.sv
module thermal_event_chk #(
  parameter int TEMP_W = 13
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     samp_valid,
  input logic signed [TEMP_W-1:0] samp_temp,
  input logic signed [TEMP_W-1:0] lim_crit,
  input logic                     evt_en,
  input logic [1:0]               mode_q,
  input logic                     event_n,
  input logic                     stat_above_high,
  input logic                     stat_below_low,
  input logic                     stat_above_crit
);

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (event_n && !stat_above_high && !stat_below_low && !stat_above_crit));

  // R2
  status_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !samp_valid |=> ($stable(stat_above_high) && $stable(stat_below_low) && $stable(stat_above_crit)));

  // R6
  cmp_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q == 2'd1 && evt_en) |=> (event_n == !(stat_above_high || stat_below_low || stat_above_crit)));

  // R7
  crit_only_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q[1] && evt_en) |=> (event_n == !stat_above_crit));

  // R8
  crit_trip_chk: assert property (@(posedge clk) disable iff (rst)
    (evt_en && samp_valid && (samp_temp > lim_crit)) |=> !event_n);

  // R9
  disabled_high_chk: assert property (@(posedge clk) disable iff (rst)
    !evt_en |=> event_n);

endmodule

bind thermal_event_ctrl thermal_event_chk #(.TEMP_W(TEMP_W)) u_chk (
  .clk             (clk),
  .rst             (rst),
  .samp_valid      (samp_valid),
  .samp_temp       (samp_temp),
  .lim_crit        (lim_crit),
  .evt_en          (evt_en),
  .mode_q          (mode_q),
  .event_n         (event_n),
  .stat_above_high (stat_above_high),
  .stat_below_low  (stat_below_low),
  .stat_above_crit (stat_above_crit)
);

// File: tb/tb_thermal_event_ctrl.sv
`timescale 1ns/1ps
module tb_thermal_event_ctrl;

  localparam int TEMP_W = 13;
  localparam int LOW = -80, HIGH = 1360, CRIT = 1520;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic samp_valid = 1'b0;
  logic signed [TEMP_W-1:0] samp_temp = '0;
  logic signed [TEMP_W-1:0] lim_low, lim_high, lim_crit;
  logic [1:0] mode_sel = 2'd0;
  logic evt_en = 1'b1;
  logic sw_clear = 1'b0;
  logic event_n, stat_above_high, stat_below_low, stat_above_crit;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  // model state
  bit m_hi, m_lo, m_cr, m_latch, m_armed, m_evn;
  int m_mode;

  always #4 clk = ~clk;

  thermal_event_ctrl #(.TEMP_W(TEMP_W)) dut (
    .clk (clk), .rst (rst), .samp_valid (samp_valid), .samp_temp (samp_temp),
    .lim_low (lim_low), .lim_high (lim_high), .lim_crit (lim_crit),
    .mode_sel (mode_sel), .evt_en (evt_en), .sw_clear (sw_clear),
    .event_n (event_n), .stat_above_high (stat_above_high),
    .stat_below_low (stat_below_low), .stat_above_crit (stat_above_crit)
  );

  task automatic check_bit(input bit act, input bit exp, input string tag);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_model(input string tag);
    vectors++;
    if ({event_n, stat_above_high, stat_below_low, stat_above_crit} !==
        {m_evn, m_hi, m_lo, m_cr}) begin
      errors++;
      $display("FAIL %s: got evn/hi/lo/cr=%b%b%b%b expected %b%b%b%b at %0t", tag,
               event_n, stat_above_high, stat_below_low, stat_above_crit,
               m_evn, m_hi, m_lo, m_cr, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; samp_valid = 1'b0; sw_clear = 1'b0;
    @(posedge clk); @(posedge clk);
    #2;
    m_hi = 0; m_lo = 0; m_cr = 0; m_latch = 0; m_armed = 1; m_evn = 1; m_mode = 0;
    compare_model("R1 reset state");
    @(negedge clk);
    rst = 1'b0;
  endtask

  // one clock: drive at negedge, update model at posedge, compare shortly after
  task automatic step(input bit v, input int t, input bit clr, input bit peek, input string tag);
    bit out_now, alarm;
    @(negedge clk);
    samp_valid = v; samp_temp = TEMP_W'(t); sw_clear = clr;
    if (peek) begin
      #2;
      check_bit(event_n, m_evn, "R3 pin unchanged before sampling edge");
    end
    @(posedge clk);
    out_now = (t > HIGH) || (t < LOW);
    if (v) begin
      m_hi = (t > HIGH); m_lo = (t < LOW); m_cr = (t > CRIT);
    end
    if (m_mode == 0) begin
      if (clr) m_latch = 0;
      if (v) begin
        if (!out_now) m_armed = 1;
        else if (m_armed) begin m_latch = 1; m_armed = 0; end
      end
    end else begin
      m_latch = 0;
      if (v) m_armed = !out_now;
    end
    case (m_mode)
      0:       alarm = m_latch | m_cr;
      1:       alarm = m_hi | m_lo | m_cr;
      default: alarm = m_cr;
    endcase
    m_evn = !(evt_en && alarm);
    m_mode = int'(mode_sel);
    #2;
    compare_model(tag);
  endtask

  task automatic sweep(input int mode, input int kind);
    int t;
    mode_sel = 2'(mode);
    step(0, 0, 0, 0, "R1 mode load");
    step(1, 0, 1, 0, "R2 settle inside");
    for (int i = 0; i < 1900; i++) begin
      case (kind)
        0:       t = -200 + i;
        1:       t = 1700 - i;
        default: t = ((i * 97) % 1900) - 200;
      endcase
      evt_en = !(i >= 600 && i < 700);
      step((i % 5) != 4, t, (i % 37) == 0, 0, "R4/R6/R7/R8 sweep");
    end
    evt_en = 1'b1;
  endtask

  initial begin
    lim_low = TEMP_W'(LOW); lim_high = TEMP_W'(HIGH); lim_crit = TEMP_W'(CRIT);
    do_reset();
    check_bit(event_n, 1'b1, "R1 event idle high after reset");

    // latching mode
    step(1, 400, 0, 0, "R4 inside");        check_bit(event_n, 1, "R4 inside no event");
    step(1, 1361, 0, 1, "R4 above high");   check_bit(event_n, 0, "R4 window event");
    check_bit(stat_above_high, 1, "R2 above high flag");
    step(0, 0, 1, 0, "R5 clear");           check_bit(event_n, 1, "R5 clear while out");
    step(1, 1500, 0, 0, "R5 no rearm");     check_bit(event_n, 1, "R5 still out not rearmed");
    step(1, 1360, 0, 0, "R2 equal high");   check_bit(stat_above_high, 0, "R2 equal to high not above");
    step(1, 1361, 0, 0, "R5 rearm");        check_bit(event_n, 0, "R5 new crossing");
    step(1, 1200, 0, 0, "R5 back in");      check_bit(event_n, 0, "R5 latched while inside");
    step(1, 1400, 1, 0, "R5 clear+set");    check_bit(event_n, 0, "R5 new event wins over clear");
    step(0, 0, 1, 0, "R5 clear");
    step(1, 1521, 0, 0, "R8 crit");         check_bit(event_n, 0, "R8 critical asserts");
    step(0, 0, 1, 0, "R8 clear");           check_bit(event_n, 0, "R8 clear ignored");
    step(1, 1520, 0, 0, "R8 equal crit");   check_bit(event_n, 1, "R8 release at limit");
    check_bit(stat_above_crit, 0, "R2 equal to crit not above");
    step(1, -80, 0, 0, "R2 equal low");     check_bit(stat_below_low, 0, "R2 equal to low not below");
    step(1, -81, 0, 0, "R4 below low");     check_bit(event_n, 0, "R4 negative excursion");
    step(0, -4000, 0, 0, "R2 no strobe");   check_bit(stat_below_low, 1, "R2 flag held without strobe");

    // enable low
    evt_en = 1'b0;
    step(1, 0, 0, 0, "R9 disabled");
    step(0, 0, 1, 0, "R9 clear");
    step(1, 1600, 0, 0, "R9 hot disabled"); check_bit(event_n, 1, "R9 held high");
    check_bit(stat_above_crit, 1, "R9 status tracks while disabled");
    evt_en = 1'b1;
    step(0, 0, 0, 0, "R9 enable");          check_bit(event_n, 0, "R9 asserts on enable");
    step(1, 0, 0, 0, "R9 cool");

    // comparator
    mode_sel = 2'd1;
    step(0, 0, 0, 0, "R6 load");
    step(1, 1400, 0, 1, "R6 hot");          check_bit(event_n, 0, "R6 follows excursion");
    step(0, 0, 1, 0, "R6 clear");           check_bit(event_n, 0, "R6 clear no effect");
    step(1, 1360, 0, 0, "R6 back");         check_bit(event_n, 1, "R6 releases inside");

    // critical-only
    mode_sel = 2'd2;
    step(0, 0, 0, 0, "R7 load");
    step(1, 1400, 0, 0, "R7 high");         check_bit(event_n, 1, "R7 window ignored high");
    step(1, -500, 0, 0, "R7 low");          check_bit(event_n, 1, "R7 window ignored low");
    step(1, 1521, 0, 0, "R7 crit");         check_bit(event_n, 0, "R7 critical asserts");
    step(1, 1520, 0, 0, "R7 release");      check_bit(event_n, 1, "R7 releases");

    for (int m = 0; m < 4; m++)
      for (int k = 0; k < 3; k++) begin
        do_reset();
        sweep(m, k);
      end

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

endmodule